// File: doc/BRIEF.md
# In-Order Store Buffer with Load Dependence Check

This block sits between the store address-generation stage and the data cache of an out-of-order core. Renamed stores are allocated into it in program order. Each entry holds the store's target address and, once known, its data. The buffer releases its oldest entry to the cache only when the commit input reports that every earlier instruction has retired. Stores therefore reach memory in program order.

Each cycle one load may present its address and an age tag for a non-speculative dependence check. The address is compared against every buffered store older than the load. It is also compared against the single store still in address generation, which is the next store to be allocated. If the youngest older matching store already holds its data, that data is forwarded to the load. Otherwise the load pipeline is told to stall. A load that matches no older store proceeds. When every entry is occupied, the block raises back-pressure toward the store pipeline.

Every store gets a sequence tag, counted from zero after reset and wrapping at twice the depth. A load's age tag is the sequence tag of the first store that is younger than the load in program order.

Top module: `store_order_buf`

## Requirements
- R1: After reset the buffer is empty, `st_full` is 0, and `cw_valid` and `chk_valid` are 0.
- R2: A `commit` pulse removes the oldest entry when that entry holds valid data. One cycle later `cw_valid` is 1, and `cw_addr`/`cw_data` carry that entry's address and data. Writes leave in allocation order.
- R3: A `commit` pulse is ignored when the buffer is empty or when the oldest entry has no valid data. In that case `cw_valid` stays 0 and the entry remains.
- R4: `st_full` is 1 exactly when the buffer holds DEPTH entries. An `alloc_valid` seen while `st_full` is 1 is dropped, and the dropped store never appears in a cache write or a forward.
- R5: A load check with `ld_valid` produces a result one cycle later with `chk_valid`=1. If the youngest older buffered store with an equal address has valid data, the result is `chk_fwd`=1, `chk_stall`=0, and `chk_data` equals that store's data.
- R6: When several older buffered stores match the load address, the youngest of them decides the outcome and supplies the forwarded data.
- R7: When the youngest older matching store has no valid data yet, the result is `chk_stall`=1 and `chk_fwd`=0.
- R8: A store whose sequence tag is equal to or younger than `ld_tag` never affects the load's result.
- R9: When `agen_valid` is 1, the store in address generation carries the next sequence tag to be allocated. If that tag is older than the load and `agen_addr` equals `ld_addr`, the result is `chk_stall`=1. Otherwise that store has no effect.
- R10: A load with no older matching store yields `chk_stall`=0 and `chk_fwd`=0. When `ld_valid` was 0, `chk_valid`, `chk_stall` and `chk_fwd` are 0.
- R11: A `fill_valid` pulse writes `fill_data` into the buffered entry whose sequence tag is `fill_tag` and marks its data valid. Later forwards and cache writes use that data.
- R12: Age comparisons stay correct after sequence tags wrap from 2*DEPTH-1 back to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| alloc_valid | input | 1 | Allocate the next store in program order |
| alloc_addr | input | ADDR_W | Address of the allocated store |
| alloc_data | input | DATA_W | Data of the allocated store |
| alloc_data_ok | input | 1 | Allocated store's data is already valid |
| st_full | output | 1 | Buffer full; allocations are dropped |
| fill_valid | input | 1 | Late data arrival for a buffered store |
| fill_tag | input | SEQ_W | Sequence tag of the store receiving data |
| fill_data | input | DATA_W | Late store data |
| commit | input | 1 | All instructions before the oldest store have retired |
| cw_valid | output | 1 | Cache write strobe |
| cw_addr | output | ADDR_W | Cache write address |
| cw_data | output | DATA_W | Cache write data |
| agen_valid | input | 1 | A store is in address generation |
| agen_addr | input | ADDR_W | Address of that store |
| ld_valid | input | 1 | Load check request |
| ld_addr | input | ADDR_W | Load address |
| ld_tag | input | SEQ_W | Tag of the first store younger than the load |
| chk_valid | output | 1 | Check result valid |
| chk_stall | output | 1 | Load must stall |
| chk_fwd | output | 1 | Forwarded data is valid |
| chk_data | output | DATA_W | Forwarded store data |

## Verification
The bench builds the buffer with DEPTH=4 and 16-bit addresses and data. With those values the 3-bit sequence tags wrap after eight stores, and the full condition is reached with four allocations, so both wraparound and dropped allocations fall inside a short run. One check places the address-generation store exactly at the boundary between older and younger than the load, with the buffer full. Forward selection is exercised both before and after the tags wrap.

// File: rtl/sob_pkg.sv
package sob_pkg;
  typedef enum logic [1:0] {
    CHK_CLEAR = 2'd0,
    CHK_FWD   = 2'd1,
    CHK_STALL = 2'd2
  } chk_kind_t;
endpackage

// File: rtl/sob_queue.sv
// Ordered store storage: allocation at the tail, release at the head, late data fill.
module sob_queue #(
  parameter int DEPTH  = 8,
  parameter int ADDR_W = 32,
  parameter int DATA_W = 32,
  localparam int PTR_W = $clog2(DEPTH),
  localparam int SEQ_W = PTR_W + 1
) (
  input  logic                          clk,
  input  logic                          rst,
  input  logic                          alloc_req,
  input  logic [ADDR_W-1:0]             alloc_addr,
  input  logic [DATA_W-1:0]             alloc_data,
  input  logic                          alloc_dv,
  input  logic                          fill_req,
  input  logic [SEQ_W-1:0]              fill_seq,
  input  logic [DATA_W-1:0]             fill_data,
  input  logic                          pop_req,
  output logic                          full,
  output logic                          pop_fire,
  output logic [ADDR_W-1:0]             head_addr,
  output logic [DATA_W-1:0]             head_data,
  output logic [SEQ_W-1:0]              head_seq,
  output logic [SEQ_W-1:0]              occ,
  output logic [DEPTH-1:0][ADDR_W-1:0]  ent_addr,
  output logic [DEPTH-1:0][DATA_W-1:0]  ent_data,
  output logic [DEPTH-1:0]              ent_dv
);
  logic [SEQ_W-1:0] head_q, tail_q;
  logic             full_q;
  logic [DEPTH-1:0] dv_q;
  logic [DEPTH-1:0][ADDR_W-1:0] addr_q;
  logic [DEPTH-1:0][DATA_W-1:0] data_q;

  logic [PTR_W-1:0] head_idx, tail_idx, fill_idx;
  logic [SEQ_W-1:0] fill_off, occ_next;
  logic             alloc_fire, fill_hit;

  assign head_idx   = head_q[PTR_W-1:0];
  assign tail_idx   = tail_q[PTR_W-1:0];
  assign fill_idx   = fill_seq[PTR_W-1:0];
  assign occ        = tail_q - head_q;
  assign alloc_fire = alloc_req && !full_q;
  assign pop_fire   = pop_req && (occ != '0) && dv_q[head_idx];
  assign fill_off   = fill_seq - head_q;
  assign fill_hit   = fill_req && (fill_off < occ);
  assign occ_next   = occ + SEQ_W'(alloc_fire) - SEQ_W'(pop_fire);

  always_ff @(posedge clk) begin
    if (rst) begin
      head_q <= '0;
      tail_q <= '0;
      full_q <= 1'b0;
      dv_q   <= '0;
    end else begin
      if (alloc_fire) begin
        tail_q         <= tail_q + 1'b1;
        dv_q[tail_idx] <= alloc_dv;
      end
      if (fill_hit)
        dv_q[fill_idx] <= 1'b1;
      if (pop_fire) begin
        head_q         <= head_q + 1'b1;
        dv_q[head_idx] <= 1'b0;
      end
      full_q <= (occ_next == SEQ_W'(DEPTH));
    end
  end

  // Payload storage carries no reset; occupancy is tracked by the pointers.
  always_ff @(posedge clk) begin
    if (alloc_fire) begin
      addr_q[tail_idx] <= alloc_addr;
      data_q[tail_idx] <= alloc_data;
    end
    if (fill_hit)
      data_q[fill_idx] <= fill_data;
  end

  assign full      = full_q;
  assign head_seq  = head_q;
  assign head_addr = addr_q[head_idx];
  assign head_data = data_q[head_idx];
  assign ent_addr  = addr_q;
  assign ent_data  = data_q;
  assign ent_dv    = dv_q;
endmodule

// File: rtl/sob_match.sv
// Age-qualified address search: youngest older buffered match plus the store in address generation.
module sob_match
  import sob_pkg::*;
#(
  parameter int DEPTH  = 8,
  parameter int ADDR_W = 32,
  parameter int DATA_W = 32,
  localparam int PTR_W = $clog2(DEPTH),
  localparam int SEQ_W = PTR_W + 1
) (
  input  logic [SEQ_W-1:0]              head_seq,
  input  logic [SEQ_W-1:0]              occ,
  input  logic [DEPTH-1:0][ADDR_W-1:0]  ent_addr,
  input  logic [DEPTH-1:0][DATA_W-1:0]  ent_data,
  input  logic [DEPTH-1:0]              ent_dv,
  input  logic [ADDR_W-1:0]             ld_addr,
  input  logic [SEQ_W-1:0]              ld_tag,
  input  logic                          agen_valid,
  input  logic [ADDR_W-1:0]             agen_addr,
  output chk_kind_t                     kind,
  output logic [DATA_W-1:0]             fwd_data
);
  logic [SEQ_W-1:0] ld_dist;
  logic [DEPTH-1:0] hit;
  logic [PTR_W-1:0] sel_idx;
  logic             found, agen_hit;

  // Distance from the oldest entry to the load's boundary tag.
  assign ld_dist = ld_tag - head_seq;

  for (genvar k = 0; k < DEPTH; k++) begin : g_cmp
    localparam logic [SEQ_W-1:0] OFF = SEQ_W'(k);
    logic [PTR_W-1:0] idx;
    assign idx    = head_seq[PTR_W-1:0] + PTR_W'(k);
    assign hit[k] = (OFF < occ) && (OFF < ld_dist) && (ent_addr[idx] == ld_addr);
  end

  // The largest offset that hits is the youngest older store.
  always_comb begin
    found   = 1'b0;
    sel_idx = '0;
    for (int k = 0; k < DEPTH; k++) begin
      if (hit[k]) begin
        found   = 1'b1;
        sel_idx = head_seq[PTR_W-1:0] + PTR_W'(k);
      end
    end
  end

  // The store in address generation takes the tail tag, so it is older
  // than the load only when the load's boundary lies beyond the tail.
  assign agen_hit = agen_valid && (ld_dist > occ) && (agen_addr == ld_addr);

  always_comb begin
    if (agen_hit)
      kind = CHK_STALL;
    else if (found)
      kind = ent_dv[sel_idx] ? CHK_FWD : CHK_STALL;
    else
      kind = CHK_CLEAR;
  end

  assign fwd_data = ent_data[sel_idx];
endmodule

// File: rtl/store_order_buf.sv
module store_order_buf
  import sob_pkg::*;
#(
  parameter int DEPTH  = 8,   // power of two, at least 2
  parameter int ADDR_W = 32,
  parameter int DATA_W = 32,
  localparam int SEQ_W = $clog2(DEPTH) + 1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              alloc_valid,
  input  logic [ADDR_W-1:0] alloc_addr,
  input  logic [DATA_W-1:0] alloc_data,
  input  logic              alloc_data_ok,
  output logic              st_full,
  input  logic              fill_valid,
  input  logic [SEQ_W-1:0]  fill_tag,
  input  logic [DATA_W-1:0] fill_data,
  input  logic              commit,
  output logic              cw_valid,
  output logic [ADDR_W-1:0] cw_addr,
  output logic [DATA_W-1:0] cw_data,
  input  logic              agen_valid,
  input  logic [ADDR_W-1:0] agen_addr,
  input  logic              ld_valid,
  input  logic [ADDR_W-1:0] ld_addr,
  input  logic [SEQ_W-1:0]  ld_tag,
  output logic              chk_valid,
  output logic              chk_stall,
  output logic              chk_fwd,
  output logic [DATA_W-1:0] chk_data
);
  logic                          pop_fire;
  logic [ADDR_W-1:0]             head_addr;
  logic [DATA_W-1:0]             head_data;
  logic [SEQ_W-1:0]              head_seq, occ;
  logic [DEPTH-1:0][ADDR_W-1:0]  ent_addr;
  logic [DEPTH-1:0][DATA_W-1:0]  ent_data;
  logic [DEPTH-1:0]              ent_dv;
  chk_kind_t                     kind;
  logic [DATA_W-1:0]             fwd_data;

  sob_queue #(.DEPTH(DEPTH), .ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_queue (
    .clk       (clk),
    .rst       (rst),
    .alloc_req (alloc_valid),
    .alloc_addr(alloc_addr),
    .alloc_data(alloc_data),
    .alloc_dv  (alloc_data_ok),
    .fill_req  (fill_valid),
    .fill_seq  (fill_tag),
    .fill_data (fill_data),
    .pop_req   (commit),
    .full      (st_full),
    .pop_fire  (pop_fire),
    .head_addr (head_addr),
    .head_data (head_data),
    .head_seq  (head_seq),
    .occ       (occ),
    .ent_addr  (ent_addr),
    .ent_data  (ent_data),
    .ent_dv    (ent_dv)
  );

  sob_match #(.DEPTH(DEPTH), .ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_match (
    .head_seq  (head_seq),
    .occ       (occ),
    .ent_addr  (ent_addr),
    .ent_data  (ent_data),
    .ent_dv    (ent_dv),
    .ld_addr   (ld_addr),
    .ld_tag    (ld_tag),
    .agen_valid(agen_valid),
    .agen_addr (agen_addr),
    .kind      (kind),
    .fwd_data  (fwd_data)
  );

  // Registered cache write port.
  always_ff @(posedge clk) begin
    if (rst) begin
      cw_valid <= 1'b0;
      cw_addr  <= '0;
      cw_data  <= '0;
    end else begin
      cw_valid <= pop_fire;
      if (pop_fire) begin
        cw_addr <= head_addr;
        cw_data <= head_data;
      end
    end
  end

  // Registered load check result.
  always_ff @(posedge clk) begin
    if (rst) begin
      chk_valid <= 1'b0;
      chk_stall <= 1'b0;
      chk_fwd   <= 1'b0;
      chk_data  <= '0;
    end else begin
      chk_valid <= ld_valid;
      chk_stall <= ld_valid && (kind == CHK_STALL);
      chk_fwd   <= ld_valid && (kind == CHK_FWD);
      chk_data  <= (ld_valid && kind == CHK_FWD) ? fwd_data : '0;
    end
  end
endmodule

// File: rtl/sob_checker.sv
module sob_checker (
  input logic clk,
  input logic rst,
  input logic alloc_valid,
  input logic commit,
  input logic st_full,
  input logic cw_valid,
  input logic ld_valid,
  input logic chk_valid,
  input logic chk_stall,
  input logic chk_fwd
);
  assert_reset_idle_R1: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> (!cw_valid && !chk_valid && !st_full));

  assert_write_needs_commit_R2: assert property (@(posedge clk) disable iff (rst)
    cw_valid |-> $past(commit));

  assert_full_holds_R4: assert property (@(posedge clk) disable iff (rst)
    (st_full && !commit) |=> st_full);

  assert_no_fill_without_alloc_R4: assert property (@(posedge clk) disable iff (rst)
    (!st_full && !alloc_valid) |=> !st_full);

  assert_outcome_exclusive_R5: assert property (@(posedge clk) disable iff (rst)
    chk_valid |-> !(chk_stall && chk_fwd));

  assert_idle_flags_R10: assert property (@(posedge clk) disable iff (rst)
    !chk_valid |-> (!chk_stall && !chk_fwd));

  assert_check_follows_R10: assert property (@(posedge clk) disable iff (rst)
    ld_valid |=> chk_valid);
endmodule

bind store_order_buf sob_checker u_sob_checker (
  .clk        (clk),
  .rst        (rst),
  .alloc_valid(alloc_valid),
  .commit     (commit),
  .st_full    (st_full),
  .cw_valid   (cw_valid),
  .ld_valid   (ld_valid),
  .chk_valid  (chk_valid),
  .chk_stall  (chk_stall),
  .chk_fwd    (chk_fwd)
);

// File: tb/store_order_buf_bench.sv
module store_order_buf_bench;
  localparam int DEPTH  = 4;
  localparam int ADDR_W = 16;
  localparam int DATA_W = 16;
  localparam int SEQ_W  = $clog2(DEPTH) + 1;

  logic              clk = 1'b0;
  logic              rst = 1'b1;
  logic              alloc_valid = 1'b0;
  logic [ADDR_W-1:0] alloc_addr = '0;
  logic [DATA_W-1:0] alloc_data = '0;
  logic              alloc_data_ok = 1'b0;
  logic              st_full;
  logic              fill_valid = 1'b0;
  logic [SEQ_W-1:0]  fill_tag = '0;
  logic [DATA_W-1:0] fill_data = '0;
  logic              commit = 1'b0;
  logic              cw_valid;
  logic [ADDR_W-1:0] cw_addr;
  logic [DATA_W-1:0] cw_data;
  logic              agen_valid = 1'b0;
  logic [ADDR_W-1:0] agen_addr = '0;
  logic              ld_valid = 1'b0;
  logic [ADDR_W-1:0] ld_addr = '0;
  logic [SEQ_W-1:0]  ld_tag = '0;
  logic              chk_valid, chk_stall, chk_fwd;
  logic [DATA_W-1:0] chk_data;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  typedef struct {
    logic [ADDR_W-1:0] addr;
    logic [DATA_W-1:0] data;
    string             req;
  } cw_item_t;

  typedef struct {
    logic              stall;
    logic              fwd;
    logic [DATA_W-1:0] data;
    string             req;
  } chk_item_t;

  cw_item_t  cw_q[$];
  chk_item_t chk_q[$];

  always #10 clk = ~clk;   // 50 MHz

  store_order_buf #(.DEPTH(DEPTH), .ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_store_order_buf (
    .clk(clk), .rst(rst),
    .alloc_valid(alloc_valid), .alloc_addr(alloc_addr), .alloc_data(alloc_data),
    .alloc_data_ok(alloc_data_ok), .st_full(st_full),
    .fill_valid(fill_valid), .fill_tag(fill_tag), .fill_data(fill_data),
    .commit(commit), .cw_valid(cw_valid), .cw_addr(cw_addr), .cw_data(cw_data),
    .agen_valid(agen_valid), .agen_addr(agen_addr),
    .ld_valid(ld_valid), .ld_addr(ld_addr), .ld_tag(ld_tag),
    .chk_valid(chk_valid), .chk_stall(chk_stall), .chk_fwd(chk_fwd), .chk_data(chk_data)
  );

  task automatic check(input bit ok, input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  // Monitor: compares every produced result with the head of its queue.
  always @(negedge clk) begin
    if (!rst && !done) begin
      if (cw_valid) begin
        if (cw_q.size() == 0) begin
          check(1'b0, "R3", "unexpected cache write addr", 32'(cw_addr), 32'h0);
        end else begin
          cw_item_t e;
          e = cw_q.pop_front();
          check(cw_addr == e.addr, e.req, "cache write addr", 32'(cw_addr), 32'(e.addr));
          check(cw_data == e.data, e.req, "cache write data", 32'(cw_data), 32'(e.data));
        end
      end
      if (chk_valid) begin
        if (chk_q.size() == 0) begin
          check(1'b0, "R10", "unexpected check result", 32'(chk_valid), 32'h0);
        end else begin
          chk_item_t c;
          c = chk_q.pop_front();
          check(chk_stall == c.stall, c.req, "stall", 32'(chk_stall), 32'(c.stall));
          check(chk_fwd == c.fwd, c.req, "forward", 32'(chk_fwd), 32'(c.fwd));
          if (c.fwd)
            check(chk_data == c.data, c.req, "forward data", 32'(chk_data), 32'(c.data));
        end
      end
    end
  end

  task automatic do_alloc(input logic [ADDR_W-1:0] a, input logic [DATA_W-1:0] d, input bit ok);
    alloc_valid = 1'b1; alloc_addr = a; alloc_data = d; alloc_data_ok = ok;
    @(negedge clk);
    alloc_valid = 1'b0; alloc_data_ok = 1'b0;
  endtask

  task automatic do_fill(input logic [SEQ_W-1:0] t, input logic [DATA_W-1:0] d);
    fill_valid = 1'b1; fill_tag = t; fill_data = d;
    @(negedge clk);
    fill_valid = 1'b0;
  endtask

  task automatic do_commit(input bit exp, input logic [ADDR_W-1:0] a,
                           input logic [DATA_W-1:0] d, input string req);
    cw_item_t e;
    commit = 1'b1;
    if (exp) begin
      e.addr = a; e.data = d; e.req = req;
      cw_q.push_back(e);
    end
    @(negedge clk);
    commit = 1'b0;
    if (!exp)
      check(cw_valid == 1'b0, req, "ignored commit wrote", 32'(cw_valid), 32'h0);
  endtask

  task automatic do_check(input logic [ADDR_W-1:0] a, input logic [SEQ_W-1:0] t,
                          input bit av, input logic [ADDR_W-1:0] aa,
                          input bit st, input bit fw, input logic [DATA_W-1:0] d,
                          input string req);
    chk_item_t c;
    ld_valid = 1'b1; ld_addr = a; ld_tag = t; agen_valid = av; agen_addr = aa;
    c.stall = st; c.fwd = fw; c.data = d; c.req = req;
    chk_q.push_back(c);
    @(negedge clk);
    ld_valid = 1'b0; agen_valid = 1'b0;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      done = 1;
      checks++; errors++;
      $display("FAIL watchdog: actual running expected finished");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R1: reset state
    check(st_full == 1'b0, "R1", "st_full", 32'(st_full), 32'h0);
    check(cw_valid == 1'b0, "R1", "cw_valid", 32'(cw_valid), 32'h0);
    check(chk_valid == 1'b0, "R1", "chk_valid", 32'(chk_valid), 32'h0);

    do_commit(1'b0, '0, '0, "R3");                    // empty buffer

    do_alloc(16'h0100, 16'h1111, 1'b1);               // seq 0
    do_alloc(16'h0200, 16'h0000, 1'b0);               // seq 1, no data
    do_alloc(16'h0100, 16'h3333, 1'b1);               // seq 2

    do_check(16'h0100, 3'd3, 1'b0, '0, 1'b0, 1'b1, 16'h3333, "R6");
    do_check(16'h0100, 3'd2, 1'b0, '0, 1'b0, 1'b1, 16'h1111, "R5");
    do_check(16'h0200, 3'd3, 1'b0, '0, 1'b1, 1'b0, '0, "R7");
    do_check(16'h0300, 3'd3, 1'b0, '0, 1'b0, 1'b0, '0, "R10");
    do_check(16'h0200, 3'd1, 1'b0, '0, 1'b0, 1'b0, '0, "R8");
    // Store in address generation takes seq 3
    do_check(16'h0400, 3'd4, 1'b1, 16'h0400, 1'b1, 1'b0, '0, "R9");
    do_check(16'h0400, 3'd3, 1'b1, 16'h0400, 1'b0, 1'b0, '0, "R9");

    do_commit(1'b1, 16'h0100, 16'h1111, "R2");        // seq 0 leaves
    do_commit(1'b0, '0, '0, "R3");                    // seq 1 lacks data
    do_fill(3'd1, 16'h2222);
    do_check(16'h0200, 3'd3, 1'b0, '0, 1'b0, 1'b1, 16'h2222, "R11");

    do_alloc(16'h0400, 16'h4444, 1'b1);               // seq 3
    check(st_full == 1'b0, "R4", "st_full at three", 32'(st_full), 32'h0);
    do_alloc(16'h0500, 16'h5555, 1'b1);               // seq 4
    check(st_full == 1'b1, "R4", "st_full at four", 32'(st_full), 32'h1);
    do_alloc(16'h0600, 16'h6666, 1'b1);               // dropped
    check(st_full == 1'b1, "R4", "st_full after drop", 32'(st_full), 32'h1);
    do_check(16'h0600, 3'd5, 1'b0, '0, 1'b0, 1'b0, '0, "R4");

    do_commit(1'b1, 16'h0200, 16'h2222, "R11");
    check(st_full == 1'b0, "R4", "st_full after commit", 32'(st_full), 32'h0);
    do_commit(1'b1, 16'h0100, 16'h3333, "R2");
    do_commit(1'b1, 16'h0400, 16'h4444, "R2");
    do_commit(1'b1, 16'h0500, 16'h5555, "R2");
    do_commit(1'b0, '0, '0, "R4");                    // dropped store never written

    // Wraparound: seq 5, 6, 7, 0
    do_alloc(16'h0700, 16'h0007, 1'b1);
    do_alloc(16'h0700, 16'h0008, 1'b1);
    do_alloc(16'h0800, 16'h0000, 1'b0);
    do_alloc(16'h0700, 16'h0009, 1'b1);
    do_check(16'h0700, 3'd0, 1'b0, '0, 1'b0, 1'b1, 16'h0008, "R12");
    do_check(16'h0700, 3'd1, 1'b0, '0, 1'b0, 1'b1, 16'h0009, "R12");
    do_check(16'h0700, 3'd6, 1'b0, '0, 1'b0, 1'b1, 16'h0007, "R12");
    do_check(16'h0800, 3'd0, 1'b0, '0, 1'b1, 1'b0, '0, "R12");
    // Store in address generation takes seq 1
    do_check(16'h0900, 3'd1, 1'b1, 16'h0900, 1'b0, 1'b0, '0, "R9");
    do_check(16'h0900, 3'd2, 1'b1, 16'h0900, 1'b1, 1'b0, '0, "R9");
    do_fill(3'd7, 16'h000A);
    do_commit(1'b1, 16'h0700, 16'h0007, "R12");
    do_commit(1'b1, 16'h0700, 16'h0008, "R12");
    do_commit(1'b1, 16'h0800, 16'h000A, "R11");
    do_commit(1'b1, 16'h0700, 16'h0009, "R12");
    do_check(16'h0700, 3'd1, 1'b0, '0, 1'b0, 1'b0, '0, "R10");

    @(negedge clk);
    check(cw_q.size() == 0, "R2", "missing cache writes", 32'(cw_q.size()), 32'h0);
    check(chk_q.size() == 0, "R5", "missing check results", 32'(chk_q.size()), 32'h0);
    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule